// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer with a small register interface on a simple 32-bit bus. The timer does not count on every clock. It counts only on pulses of a slow reference tick. A programmable prescaler divides those ticks, and each prescaled step takes one from a 16-bit down-counter. If software lets the counter reach zero while the timer is enabled, the block raises a reset request for the system. That request stays set until the block itself is reset.

Each write is protected by a fixed key. The upper half-word of the written data must be 0x1234, and only the lower half-word is stored. Writing the divisor or load value does not change the timer's behaviour straight away: the new value waits as pending. Software activates it by flipping a two-bit group code in the refresh register. Three such groups exist. One commits the divisor, one reloads the counter (this is also how software services the watchdog), and one is a stored interrupt-value code that does not act on the timer.

Top module: `kwdog_top`

## Requirements
- R1: A write whose upper half-word is not 0x1234 is ignored: no register changes, and no refresh group fires.
- R2: A read of offset 0x04 (config), 0x08 (load), 0x18 (refresh) or 0x1C (control) returns the stored 16-bit value in bits 15:0 and zero in bits 31:16. A read of any other offset returns zero.
- R3: After reset, config reads 0x0F00 (divisor 16), load reads 0xFFFF, refresh reads 0x0015 (each group holds 1), control reads 0x0000, the active counter holds 0xFFFF and rst_req is low.
- R4: A newly written load value has no effect on counting until the counter group (refresh bits 3:2) toggles.
- R5: When the counter group toggles between codes 1 and 2, the active counter is loaded from the load register and the prescaler phase is cleared, on the same clock edge as the write.
- R6: When the configuration group (refresh bits 5:4) toggles between 1 and 2, config bits 15:8 become the active divisor minus one. The counter then drops by one for every (field+1) reference ticks that arrive while enabled.
- R7: A group whose old or new code is 0 or 3, or whose code is unchanged, triggers nothing.
- R8: Bit 0 of the control register enables counting. While it is 0, the counter and the prescaler hold their values. The other control bits are stored and read back.
- R9: Once the enabled counter holds zero, rst_req rises on the next clock edge. After that it stays high until reset, even if the timer is stopped.
- R10: A toggle of the interrupt-value group (refresh bits 1:0) is stored but reloads neither the counter nor the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the reference counting rate |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data: key in 31:16, value in 15:0 |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rst_req | output | 1 | Sticky reset request on timeout |

## Verification
The assertions check the following on every cycle:
- keyed writes that lose their key leave all four registers unchanged;
- read data always has a zero upper half;
- without a refresh write, the counter moves by at most one per cycle and holds while disabled;
- a counter-group toggle loads the pending value;
- the reset request follows a zero count and never falls.

Some behaviours can only be shown by the bench's scenarios. These are the exact number of reference ticks per step for a given divisor, pending values staying inactive over many ticks, and the rejection of the invalid group codes 0 and 3.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
    localparam int          REG_W   = 16;
    localparam int          BUS_W   = 32;
    localparam logic [15:0] WR_KEY  = 16'h1234;

    // Register offsets (byte addresses)
    localparam logic [7:0] OFS_CFG   = 8'h04;
    localparam logic [7:0] OFS_LOAD  = 8'h08;
    localparam logic [7:0] OFS_REFR  = 8'h18;
    localparam logic [7:0] OFS_CTRL  = 8'h1C;

    // Divisor field inside the config register
    localparam int DIV_LSB = 8;
    localparam int DIV_W   = 8;

    // Reset values
    localparam logic [15:0] CFG_RST  = 16'h0F00;
    localparam logic [15:0] LOAD_RST = 16'hFFFF;
    localparam logic [15:0] REFR_RST = 16'h0015;
    localparam logic [15:0] CTRL_RST = 16'h0000;

    // Refresh groups: index g covers bits 2g+1:2g
    localparam int N_GRP   = 3;
    localparam int GRP_INT = 0;
    localparam int GRP_CNT = 1;
    localparam int GRP_CFG = 2;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] load;
        logic [REG_W-1:0] refr;
        logic [REG_W-1:0] ctrl;
    } regs_t;

    // A group fires only on a change between the two legal codes
    function automatic logic grp_fire(input logic [1:0] old_c, input logic [1:0] new_c);
        return ((old_c == 2'd1) || (old_c == 2'd2)) &&
               ((new_c == 2'd1) || (new_c == 2'd2)) &&
               (old_c != new_c);
    endfunction
endpackage

// File: rtl/kwdog_regs.sv
module kwdog_regs
    import kwdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output regs_t             regs_q,
    output logic [N_GRP-1:0]  fire
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_REFR = ADDR_W'(OFS_REFR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    regs_t            regs_d;
    logic             wr_ok;
    logic [REG_W-1:0] wval;
    logic [REG_W-1:0] rval;

    assign wr_ok = bus_valid && bus_write && (bus_wdata[BUS_W-1:REG_W] == WR_KEY);
    assign wval  = bus_wdata[REG_W-1:0];

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) begin
            case (bus_addr)
                A_CFG:   regs_d.cfg  = wval;
                A_LOAD:  regs_d.load = wval;
                A_REFR:  regs_d.refr = wval;
                A_CTRL:  regs_d.ctrl = wval;
                default: regs_d = regs_q;
            endcase
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign fire[g] = wr_ok && (bus_addr == A_REFR) &&
                         grp_fire(regs_q.refr[2*g+1:2*g], wval[2*g+1:2*g]);
    end

    always_comb begin
        rval = '0;
        if (bus_valid && !bus_write) begin
            case (bus_addr)
                A_CFG:   rval = regs_q.cfg;
                A_LOAD:  rval = regs_q.load;
                A_REFR:  rval = regs_q.refr;
                A_CTRL:  rval = regs_q.ctrl;
                default: rval = '0;
            endcase
        end
    end
    assign bus_rdata = {{(BUS_W-REG_W){1'b0}}, rval};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.cfg  <= CFG_RST;
            regs_q.load <= LOAD_RST;
            regs_q.refr <= REFR_RST;
            regs_q.ctrl <= CTRL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/kwdog_prescale.sv
module kwdog_prescale #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             commit,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_new,
    output logic             step
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] pre;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        step = 1'b0;
        if (commit) begin
            ps_d.div = div_new;
            ps_d.pre = '0;
        end else if (restart) begin
            ps_d.pre = '0;
        end else if (en && tick) begin
            if (ps_q.pre >= ps_q.div) begin
                ps_d.pre = '0;
                step     = 1'b1;
            end else begin
                ps_d.pre = ps_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q.div <= DIV_W'(DIV_RST);
            ps_q.pre <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end
endmodule

// File: rtl/kwdog_counter.sv
module kwdog_counter #(
    parameter int CNT_W            = 16,
    parameter logic [CNT_W-1:0] CNT_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             exp;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (reload) begin
            cs_d.cnt = load_val;
        end else if (step && (cs_q.cnt != '0)) begin
            cs_d.cnt = cs_q.cnt - 1'b1;
        end
        cs_d.exp = cs_q.exp | (en && (cs_q.cnt == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q.cnt <= CNT_RST;
            cs_q.exp <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count   = cs_q.cnt;
    assign expired = cs_q.exp;
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
    import kwdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    localparam int DIV_RST = int'(CFG_RST[DIV_LSB +: DIV_W]);

    regs_t            regs_q;
    logic [N_GRP-1:0] fire;
    logic             step;
    logic             run_en;
    logic [REG_W-1:0] cnt_q;
    logic             unused_bits;

    assign run_en = regs_q.ctrl[0];

    kwdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .regs_q    (regs_q),
        .fire      (fire)
    );

    kwdog_prescale #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .tick    (ref_tick),
        .commit  (fire[GRP_CFG]),
        .restart (fire[GRP_CNT]),
        .div_new (regs_q.cfg[DIV_LSB +: DIV_W]),
        .step    (step)
    );

    kwdog_counter #(.CNT_W(REG_W), .CNT_RST(LOAD_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .step     (step),
        .reload   (fire[GRP_CNT]),
        .load_val (regs_q.load),
        .count    (cnt_q),
        .expired  (rst_req)
    );

    // The interrupt-value group is only stored (R10)
    assign unused_bits = ^{fire[GRP_INT], regs_q.refr, regs_q.ctrl[REG_W-1:1],
                           regs_q.cfg[DIV_LSB-1:0], cnt_q};
endmodule

// File: rtl/kwdog_check.sv
module kwdog_check
    import kwdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input regs_t             regs_q,
    input logic [REG_W-1:0]  cnt_q,
    input logic              rst_req
);
    logic key_bad;
    logic refr_wr;
    logic cnt_grp_fire;

    assign key_bad      = bus_valid && bus_write && (bus_wdata[31:16] != WR_KEY);
    assign refr_wr      = bus_valid && bus_write && (bus_wdata[31:16] == WR_KEY) &&
                          (bus_addr == ADDR_W'(OFS_REFR));
    assign cnt_grp_fire = refr_wr && grp_fire(regs_q.refr[3:2], bus_wdata[3:2]);

    assert_bad_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> ($stable(regs_q.cfg) && $stable(regs_q.load) &&
                     $stable(regs_q.refr) && $stable(regs_q.ctrl)));

    assert_read_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_grp_fire |=> (cnt_q == $past(regs_q.load)));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !refr_wr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 16'd1)));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.ctrl[0] && !refr_wr) |=> $stable(cnt_q));

    assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl[0] && (cnt_q == 16'h0)) |=> rst_req);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind kwdog_top kwdog_check #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .regs_q    (regs_q),
    .cnt_q     (cnt_q),
    .rst_req   (rst_req)
);

// File: tb/tb_kwdog_top.sv
module tb_kwdog_top;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_tick = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rst_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    kwdog_top #(.ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    // {addr[55:48], wdata[47:16], expected readback[15:0]}
    localparam int NV = 8;
    localparam logic [55:0] VEC [NV] = '{
        {8'h08, 32'h1234_00AB, 16'h00AB},  // R1 keyed write stored
        {8'h08, 32'h4321_0055, 16'h00AB},  // R1 bad key ignored
        {8'h04, 32'h1234_0300, 16'h0300},
        {8'h04, 32'h0000_FFFF, 16'h0300},  // R1 bad key ignored
        {8'h1C, 32'h1234_00F0, 16'h00F0},  // R8 other bits stored
        {8'h18, 32'h1234_0015, 16'h0015},
        {8'h10, 32'h1234_5555, 16'h0000},  // R2 unmapped reads zero
        {8'h1C, 32'h1234_A5A4, 16'hA5A4}   // R8
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [15:0] e, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v === {16'h0, e}, req, v, {16'h0, e});
    endtask

    task automatic expect_req(input logic e, input string req);
        check(rst_req === e, req, {31'h0, rst_req}, {31'h0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][55:48], VEC[i][47:16]);
            expect_rd(VEC[i][55:48], VEC[i][15:0], "R1/R2/R8 table");
        end

        // R3 reset values
        do_reset();
        expect_rd(8'h04, 16'h0F00, "R3 cfg");
        expect_rd(8'h08, 16'hFFFF, "R3 load");
        expect_rd(8'h18, 16'h0015, "R3 refresh");
        expect_rd(8'h1C, 16'h0000, "R3 ctrl");
        expect_req(1'b0, "R3 rst_req");

        // R5 / R9: reload to 3 at divisor 1, expire exactly
        wr(8'h04, 32'h1234_0000);
        wr(8'h18, 32'h1234_0025);
        wr(8'h08, 32'h1234_0003);
        wr(8'h18, 32'h1234_0029);
        wr(8'h1C, 32'h1234_0001);
        ticks(2);
        expect_req(1'b0, "R5 count 1 left");
        ticks(1);
        expect_req(1'b0, "R9 zero not yet seen");
        @(negedge clk);
        expect_req(1'b1, "R9 asserts edge after zero");
        wr(8'h1C, 32'h1234_0000);
        wr(8'h1C, 32'hBEEF_0000);
        repeat (3) @(negedge clk);
        expect_req(1'b1, "R9 sticky after stop");
        expect_rd(8'h18, 16'h0029, "R5 refresh stored");

        // R4: pending load inactive until counter group toggles
        do_reset();
        wr(8'h04, 32'h1234_0000);
        wr(8'h18, 32'h1234_0025);
        wr(8'h1C, 32'h1234_0001);
        wr(8'h08, 32'h1234_0002);
        ticks(3);
        expect_req(1'b0, "R4 pending load unused");
        wr(8'h18, 32'h1234_0029);
        ticks(2);
        @(negedge clk);
        expect_req(1'b1, "R5 reload then expire");

        // R6: divisor 3 (field 2), load 2 -> 6 ticks
        do_reset();
        wr(8'h04, 32'h1234_0200);
        wr(8'h08, 32'h1234_0002);
        wr(8'h18, 32'h1234_0029);
        wr(8'h1C, 32'h1234_0001);
        ticks(5);
        @(negedge clk);
        expect_req(1'b0, "R6 five ticks short");
        ticks(1);
        @(negedge clk);
        expect_req(1'b1, "R6 sixth tick expires");

        // R7: invalid codes and unchanged codes do nothing
        do_reset();
        wr(8'h04, 32'h1234_0000);
        wr(8'h18, 32'h1234_0025);
        wr(8'h08, 32'h1234_0001);
        wr(8'h18, 32'h1234_002D);  // cnt 01->11
        wr(8'h1C, 32'h1234_0001);
        ticks(3);
        expect_req(1'b0, "R7 01->11 no reload");
        wr(8'h18, 32'h1234_0021);  // 11->00
        wr(8'h18, 32'h1234_0029);  // 00->10
        wr(8'h18, 32'h1234_0029);  // unchanged
        ticks(2);
        @(negedge clk);
        expect_req(1'b0, "R7 00->10 and same no reload");
        wr(8'h18, 32'h1234_0025);  // 10->01 fires
        ticks(1);
        @(negedge clk);
        expect_req(1'b1, "R7 valid toggle reloads");

        // R10: interrupt-value group does not reload
        do_reset();
        wr(8'h04, 32'h1234_0000);
        wr(8'h18, 32'h1234_0025);
        wr(8'h08, 32'h1234_0001);
        wr(8'h18, 32'h1234_0026);
        wr(8'h1C, 32'h1234_0001);
        ticks(2);
        @(negedge clk);
        expect_req(1'b0, "R10 no reload from int group");
        expect_rd(8'h18, 16'h0026, "R10 stored");

        // R8: disabled counter freezes
        do_reset();
        wr(8'h04, 32'h1234_0000);
        wr(8'h08, 32'h1234_0002);
        wr(8'h18, 32'h1234_0029);
        wr(8'h1C, 32'h1234_0000);
        ticks(5);
        @(negedge clk);
        expect_req(1'b0, "R8 frozen while disabled");
        wr(8'h1C, 32'h1234_0001);
        ticks(2);
        @(negedge clk);
        expect_req(1'b1, "R8 counts once enabled");

        // R1: bad-key refresh does not reload
        do_reset();
        wr(8'h04, 32'h1234_0000);
        wr(8'h18, 32'h1234_0025);
        wr(8'h08, 32'h1234_0001);
        wr(8'h18, 32'h0000_0029);
        wr(8'h1C, 32'h1234_0001);
        ticks(2);
        @(negedge clk);
        expect_req(1'b0, "R1 bad-key refresh ignored");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule